// File: doc/BRIEF.md
# DSI Command Packet Assembler

This block turns one display-serial-interface command into the exact sequence of 32-bit words that a transmit buffer expects. A command carries a 2-bit virtual channel, a 6-bit data type, a short/long selector and a 16-bit field. For a short packet that field holds two parameter bytes. For a long packet it holds the payload length. The block always builds the 4-byte header and protects it with an 8-bit error-correcting code. For long packets it then takes the payload one byte at a time over a valid/ready port, runs a 16-bit CRC over it and appends the result.

All bytes leave little-endian, four to a word, one word per cycle, with the final word marked and the packet's total byte count presented alongside it. Any long packet that would not fit in the configured word budget is refused at once. A refusal raises a one-cycle error pulse and no words are produced.

Top module: `dsi_pkt_asm`

## Requirements
- R1: The header word holds `{data type}` in bits 5:0, the virtual channel in bits 7:6, and the 16-bit field in bits 23:8 with its low byte in bits 15:8. It is the first word of every packet and appears the cycle after the command is accepted.
- R2: Header bits 31:24 are the XOR of one 6-bit constant for each set bit among header bits 23:0, so bits 31:30 are always 0. The constants in hex for header bits 0 through 23 are: 07 0B 0D 0E 13 15 16 19 1A 1C 23 25 26 29 2A 2C 31 32 34 38 1F 2F 37 3B.
- R3: A short packet is a single word with `word_last` set and `pkt_bytes` = 4. It never raises `pay_ready`.
- R4: A long packet's checksum starts at FFFFh and consumes each payload byte least significant bit first. For each bit, if (crc bit 0) XOR (data bit) is 1, crc becomes (crc >> 1) XOR 8408h; otherwise crc becomes crc >> 1. The two checksum bytes follow the payload, low byte first.
- R5: Header, payload and checksum bytes are packed in order, four per word, with the earliest byte in bits 7:0. The unused upper bytes of a final partial word are zero.
- R6: On the word carrying `word_last`, `pkt_bytes` equals 4 for a short packet and 4 + length + 2 for a long one. The number of words equals that count divided by 4, rounded up.
- R7: A long packet whose length exceeds 4*MAX_WORDS - 6 bytes is refused. `pkt_err` pulses the cycle after acceptance, no word is emitted and no payload is requested.
- R8: The checksum is restarted for every packet, so two consecutive long packets with equal payloads yield equal checksums.
- R9: `cmd_ready` is high only when no packet is in progress. `pay_ready` is high only while payload bytes remain. The two are never high together, and `word_last` appears only with `word_valid`.
- R10: A long packet of length 0 produces the header word followed by one word containing only the two checksum bytes FFh FFh, with 6 bytes in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Assembler idle, command accepted when valid |
| cmd_vc | input | 2 | Virtual channel |
| cmd_dt | input | 6 | Data type |
| cmd_long | input | 1 | 1 selects a long packet |
| cmd_wc | input | 16 | Short parameters or long payload length |
| pay_valid | input | 1 | Payload byte offered |
| pay_ready | output | 1 | Payload byte wanted |
| pay_data | input | 8 | Payload byte |
| word_valid | output | 1 | Output word strobe |
| word_data | output | 32 | Packed packet word |
| word_last | output | 1 | Final word of the packet |
| pkt_bytes | output | 16 | Total packet bytes, meaningful with word_last |
| pkt_err | output | 1 | One-cycle refusal pulse |

## Verification
The properties assume that command fields are steady and known whenever `cmd_valid` is high. They also assume that `pay_valid` is only raised for bytes that belong to the current packet, and that inputs are held at 0 during reset. The bench drives every input from the falling edge, drops `cmd_valid` right after the accepting edge, and offers payload bytes only while a long packet is open. Gaps are inserted on `pay_valid` to vary the timing without ever supplying a byte beyond the declared length.

// File: rtl/dsi_pkt_pkg.sv
package dsi_pkt_pkg;

    localparam int          FIELD_W   = 16;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY  = 16'h8408;
    localparam int          HDR_BYTES = 4;
    localparam int          CRC_BYTES = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PAY,
        ST_CRC_LO,
        ST_CRC_HI
    } asm_st_e;

    typedef struct packed {
        asm_st_e              st;
        logic [15:0]          crc;
        logic [FIELD_W-1:0]   remain;
        logic [31:0]          lanes;
        logic [1:0]           idx;
        logic                 wvalid;
        logic [31:0]          wdata;
        logic                 wlast;
        logic [FIELD_W-1:0]   bytes;
        logic                 err;
    } asm_reg_t;

endpackage

// File: rtl/dsi_hdr_ecc.sv
module dsi_hdr_ecc (
    input  logic [23:0] hdr_bits,
    output logic [7:0]  ecc_byte
);
    localparam int PAR_N = 6;

    // Each mask selects the header bits whose parity constant has bit k set.
    localparam logic [23:0] PAR_MASK [PAR_N] = '{
        24'hF12CB7,
        24'hF2555B,
        24'h749A6D,
        24'hB8E38E,
        24'hDF03F0,
        24'hEFFC00
    };

    logic [PAR_N-1:0] par;

    generate
        for (genvar k = 0; k < PAR_N; k++) begin : g_par
            assign par[k] = ^(hdr_bits & PAR_MASK[k]);
        end
    endgenerate

    assign ecc_byte = {2'b00, par};

endmodule

// File: rtl/dsi_crc16_step.sv
module dsi_crc16_step
    import dsi_pkt_pkg::*;
(
    input  logic [15:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);
    logic [15:0] acc;
    logic [7:0]  sh;

    always_comb begin
        acc = crc_in;
        sh  = data_in;
        for (int b = 0; b < 8; b++) begin
            if (acc[0] ^ sh[0]) acc = (acc >> 1) ^ CRC_POLY;
            else                acc = acc >> 1;
            sh = sh >> 1;
        end
        crc_out = acc;
    end

endmodule

// File: rtl/dsi_lane_insert.sv
module dsi_lane_insert #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0]         lanes_in,
    input  logic [$clog2(LANES)-1:0]   slot,
    input  logic [7:0]                 byte_in,
    output logic [8*LANES-1:0]         lanes_out
);
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lanes_out[8*l +: 8] = (slot == l[$clog2(LANES)-1:0])
                                         ? byte_in : lanes_in[8*l +: 8];
        end
    endgenerate

endmodule

// File: rtl/dsi_pkt_asm.sv
module dsi_pkt_asm
    import dsi_pkt_pkg::*;
#(
    parameter int MAX_WORDS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_vc,
    input  logic [5:0]  cmd_dt,
    input  logic        cmd_long,
    input  logic [15:0] cmd_wc,
    input  logic        pay_valid,
    output logic        pay_ready,
    input  logic [7:0]  pay_data,
    output logic        word_valid,
    output logic [31:0] word_data,
    output logic        word_last,
    output logic [15:0] pkt_bytes,
    output logic        pkt_err
);
    localparam int MAX_PAY   = 4 * MAX_WORDS - HDR_BYTES - CRC_BYTES;
    localparam int OVERHEAD  = HDR_BYTES + CRC_BYTES;

    localparam asm_reg_t RST_VAL = '{
        st:     ST_IDLE,
        crc:    CRC_SEED,
        remain: '0,
        lanes:  '0,
        idx:    '0,
        wvalid: 1'b0,
        wdata:  '0,
        wlast:  1'b0,
        bytes:  '0,
        err:    1'b0
    };

    asm_reg_t q, d;

    logic [23:0] hdr_bits;
    logic [7:0]  hdr_ecc;
    logic [15:0] crc_next;
    logic [7:0]  ins_byte;
    logic [31:0] lanes_ins;
    logic        too_long;

    assign hdr_bits = {cmd_wc, cmd_vc, cmd_dt};
    assign too_long = cmd_long && (32'(cmd_wc) > MAX_PAY);

    dsi_hdr_ecc u_ecc (
        .hdr_bits (hdr_bits),
        .ecc_byte (hdr_ecc)
    );

    dsi_crc16_step u_crc (
        .crc_in  (q.crc),
        .data_in (pay_data),
        .crc_out (crc_next)
    );

    always_comb begin
        case (q.st)
            ST_CRC_LO: ins_byte = q.crc[7:0];
            ST_CRC_HI: ins_byte = q.crc[15:8];
            default:   ins_byte = pay_data;
        endcase
    end

    dsi_lane_insert #(.LANES(4)) u_ins (
        .lanes_in  (q.lanes),
        .slot      (q.idx),
        .byte_in   (ins_byte),
        .lanes_out (lanes_ins)
    );

    always_comb begin
        d        = q;
        d.wvalid = 1'b0;
        d.wlast  = 1'b0;
        d.err    = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (too_long) begin
                        d.err = 1'b1;
                    end else begin
                        d.wvalid = 1'b1;
                        d.wdata  = {hdr_ecc, hdr_bits};
                        d.crc    = CRC_SEED;
                        d.lanes  = '0;
                        d.idx    = '0;
                        d.remain = cmd_wc;
                        if (!cmd_long) begin
                            d.wlast = 1'b1;
                            d.bytes = 16'(HDR_BYTES);
                        end else begin
                            d.bytes = cmd_wc + 16'(OVERHEAD);
                            d.st    = (cmd_wc == '0) ? ST_CRC_LO : ST_PAY;
                        end
                    end
                end
            end

            ST_PAY: begin
                if (pay_valid) begin
                    d.crc    = crc_next;
                    d.idx    = q.idx + 2'd1;
                    d.remain = q.remain - 16'd1;
                    if (q.idx == 2'd3) begin
                        d.wvalid = 1'b1;
                        d.wdata  = lanes_ins;
                        d.lanes  = '0;
                    end else begin
                        d.lanes  = lanes_ins;
                    end
                    if (q.remain == 16'd1) d.st = ST_CRC_LO;
                end
            end

            ST_CRC_LO: begin
                d.idx = q.idx + 2'd1;
                d.st  = ST_CRC_HI;
                if (q.idx == 2'd3) begin
                    d.wvalid = 1'b1;
                    d.wdata  = lanes_ins;
                    d.lanes  = '0;
                end else begin
                    d.lanes  = lanes_ins;
                end
            end

            ST_CRC_HI: begin
                d.wvalid = 1'b1;
                d.wlast  = 1'b1;
                d.wdata  = lanes_ins;
                d.lanes  = '0;
                d.idx    = '0;
                d.st     = ST_IDLE;
            end

            default: d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign cmd_ready  = (q.st == ST_IDLE);
    assign pay_ready  = (q.st == ST_PAY);
    assign word_valid = q.wvalid;
    assign word_data  = q.wdata;
    assign word_last  = q.wlast;
    assign pkt_bytes  = q.bytes;
    assign pkt_err    = q.err;

endmodule

// File: rtl/dsi_pkt_asm_chk.sv
module dsi_pkt_asm_chk #(
    parameter int MAX_WORDS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_ready,
    input  logic [1:0]  cmd_vc,
    input  logic [5:0]  cmd_dt,
    input  logic        cmd_long,
    input  logic [15:0] cmd_wc,
    input  logic        pay_ready,
    input  logic        word_valid,
    input  logic [31:0] word_data,
    input  logic        word_last,
    input  logic [15:0] pkt_bytes,
    input  logic        pkt_err
);
    localparam int LIMIT = 4 * MAX_WORDS - 6;

    logic        take;
    logic        refuse;
    logic [15:0] wcnt_q;

    assign take   = cmd_valid && cmd_ready;
    assign refuse = take && cmd_long && (32'(cmd_wc) > LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wcnt_q <= '0;
        else if (word_valid) wcnt_q <= word_last ? 16'd0 : wcnt_q + 16'd1;
    end

    a_r1_header_fields: assert property (@(posedge clk) disable iff (!rst_n)
        take && !refuse |=> word_valid && word_data[23:0] == $past({cmd_wc, cmd_vc, cmd_dt}));

    a_r2_ecc_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        take && !refuse |=> word_data[31:30] == 2'b00);

    a_r3_short_single: assert property (@(posedge clk) disable iff (!rst_n)
        take && !cmd_long |=> word_last && pkt_bytes == 16'd4);

    a_r6_word_count: assert property (@(posedge clk) disable iff (!rst_n)
        word_last |-> (32'(wcnt_q) + 1) == ((32'(pkt_bytes) + 3) >> 2));

    a_r6_bytes_bound: assert property (@(posedge clk) disable iff (!rst_n)
        word_last |-> 32'(pkt_bytes) <= 4 * MAX_WORDS);

    a_r7_refuse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> pkt_err && !word_valid && cmd_ready);

    a_r9_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ready, pay_ready}));

    a_r9_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        word_last |-> word_valid);

endmodule

bind dsi_pkt_asm dsi_pkt_asm_chk #(.MAX_WORDS(MAX_WORDS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_vc     (cmd_vc),
    .cmd_dt     (cmd_dt),
    .cmd_long   (cmd_long),
    .cmd_wc     (cmd_wc),
    .pay_ready  (pay_ready),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_last  (word_last),
    .pkt_bytes  (pkt_bytes),
    .pkt_err    (pkt_err)
);

// File: tb/dsi_pkt_asm_tb_top.sv
`timescale 1ns/1ps
module dsi_pkt_asm_tb_top;
    localparam int MAXW  = 8;
    localparam int LIMIT = 4 * MAXW - 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_vc = '0;
    logic [5:0]  cmd_dt = '0;
    logic        cmd_long = 1'b0;
    logic [15:0] cmd_wc = '0;
    logic        pay_valid = 1'b0;
    logic        pay_ready;
    logic [7:0]  pay_data = '0;
    logic        word_valid;
    logic [31:0] word_data;
    logic        word_last;
    logic [15:0] pkt_bytes;
    logic        pkt_err;

    always #2 clk = ~clk;

    dsi_pkt_asm #(.MAX_WORDS(MAXW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_vc(cmd_vc), .cmd_dt(cmd_dt), .cmd_long(cmd_long), .cmd_wc(cmd_wc),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .word_valid(word_valid), .word_data(word_data), .word_last(word_last),
        .pkt_bytes(pkt_bytes), .pkt_err(pkt_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0]  exp_b [0:63];
    int          exp_n;
    logic [31:0] got_w [0:15];
    int          got_n;
    int          got_bytes;
    bit          got_last;
    bit          got_err;
    int          pay_cyc;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] ecc_ref(input logic [23:0] h);
        logic [7:0] tbl [0:23] = '{8'h07, 8'h0B, 8'h0D, 8'h0E, 8'h13, 8'h15, 8'h16, 8'h19,
                                   8'h1A, 8'h1C, 8'h23, 8'h25, 8'h26, 8'h29, 8'h2A, 8'h2C,
                                   8'h31, 8'h32, 8'h34, 8'h38, 8'h1F, 8'h2F, 8'h37, 8'h3B};
        logic [7:0] e = 8'h00;
        for (int i = 0; i < 24; i++) if (h[i]) e ^= tbl[i];
        return e;
    endfunction

    function automatic logic [7:0] pay_byte(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5 + (i * i) * 3) & 255);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                if (got_n < 16) got_w[got_n] = word_data;
                got_n++;
                if (word_last) begin
                    got_last  = 1'b1;
                    got_bytes = int'(pkt_bytes);
                end
            end
            if (pkt_err)   got_err = 1'b1;
            if (pay_ready) pay_cyc++;
        end
    end

    task automatic run_pkt(input logic [1:0] vc, input logic [5:0] dt, input bit lng,
                           input logic [15:0] wc, input int seed, input string req);
        logic [23:0] h;
        logic [15:0] crc;
        bit refuse;
        int words;
        h = {wc, vc, dt};
        refuse = lng && (int'(wc) > LIMIT);
        exp_b[0] = h[7:0]; exp_b[1] = h[15:8]; exp_b[2] = h[23:16]; exp_b[3] = ecc_ref(h);
        exp_n = 4;
        if (lng && !refuse) begin
            crc = 16'hFFFF;
            for (int i = 0; i < int'(wc); i++) begin
                logic [7:0] b;
                b = pay_byte(seed, i);
                exp_b[exp_n++] = b;
                for (int k = 0; k < 8; k++) begin
                    if (crc[0] ^ b[k]) crc = (crc >> 1) ^ 16'h8408;
                    else               crc = crc >> 1;
                end
            end
            exp_b[exp_n++] = crc[7:0];
            exp_b[exp_n++] = crc[15:8];
        end
        for (int i = exp_n; i < 64; i++) exp_b[i] = 8'h00;
        words = (exp_n + 3) / 4;

        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        got_n = 0; got_last = 0; got_err = 0; got_bytes = 0; pay_cyc = 0;
        cmd_vc = vc; cmd_dt = dt; cmd_long = lng; cmd_wc = wc; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (lng && !refuse) begin
            int i = 0;
            int cyc = 0;
            while (i < int'(wc) && cyc < 1000) begin
                bit g;
                bit r;
                g = ((cyc + seed) % 5) != 0;
                r = pay_ready;
                pay_data  = pay_byte(seed, i);
                pay_valid = g;
                @(negedge clk);
                if (g && r) i++;
                cyc++;
            end
            pay_valid = 1'b0;
        end
        for (int t = 0; t < 20 && !got_last && !got_err; t++) @(negedge clk);
        @(negedge clk);

        if (refuse) begin
            check(got_err, {req, " refusal pulse"}, got_err, 1);
            check(got_n == 0, {req, " refused words"}, got_n, 0);
            check(pay_cyc == 0, {req, " refused payload request"}, pay_cyc, 0);
        end else begin
            check(got_last && got_n == words, {req, " word count"}, got_n, words);
            check(got_bytes == exp_n, {req, " byte count"}, got_bytes, exp_n);
            if (!lng) check(pay_cyc == 0, {req, " R3 short payload request"}, pay_cyc, 0);
            for (int j = 0; j < words && j < 16; j++) begin
                logic [31:0] ew;
                ew = {exp_b[4*j+3], exp_b[4*j+2], exp_b[4*j+1], exp_b[4*j]};
                check(j < got_n && got_w[j] === ew, {req, " word data"}, got_w[j], ew);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready === 1'b1, "R9 reset cmd_ready", cmd_ready, 1);
        check(pay_ready === 1'b0, "R9 reset pay_ready", pay_ready, 0);
        check(word_valid === 1'b0, "R9 reset word_valid", word_valid, 0);

        // R2 and R1: every single header bit, then mixed patterns
        for (int b = 0; b < 24; b++) begin
            logic [23:0] h;
            h = 24'h1 << b;
            run_pkt(h[7:6], h[5:0], 1'b0, h[23:8], b, "R1 R2 R3 single-bit header");
        end
        for (int s = 0; s < 40; s++) begin
            logic [23:0] h;
            h = 24'((s * 24'h9E3779) ^ (s << 13) ^ 24'hA5C3);
            run_pkt(h[7:6], h[5:0], 1'b0, h[23:8], s, "R1 R2 R3 mixed header");
        end

        // R4 R5 R6 R10: every admissible payload length
        for (int len = 0; len <= LIMIT; len++)
            run_pkt(2'(len), 6'h39, 1'b1, 16'(len), len + 7, "R4 R5 R6 R10 long packet");

        // R7: refused lengths
        run_pkt(2'd1, 6'h29, 1'b1, 16'(LIMIT + 1), 3, "R7 just over limit");
        run_pkt(2'd2, 6'h29, 1'b1, 16'(LIMIT + 9), 3, "R7 over limit");
        run_pkt(2'd3, 6'h29, 1'b1, 16'hFFFF, 3, "R7 max length");
        // short packet with a large field is never refused
        run_pkt(2'd0, 6'h05, 1'b0, 16'hFFFF, 3, "R3 R7 short large field");

        // R8: identical long packets back to back
        run_pkt(2'd0, 6'h39, 1'b1, 16'd5, 11, "R8 first");
        run_pkt(2'd0, 6'h39, 1'b1, 16'd5, 11, "R8 repeat");
        run_pkt(2'd0, 6'h39, 1'b1, 16'd0, 11, "R8 R10 empty after long");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule